// File: doc/BRIEF.md
# LIN Frame Checksum Unit

This block forms the 8-bit checksum of a LIN frame from a stream of bytes handed to it one per cycle. Every byte is added into an 8-bit accumulator with end-around carry: any carry out of the top bit is added back into the low byte on the same addition, so the accumulator always stays 8 bits wide. When the frame ends, the accumulated sum is inverted to give the checksum that goes on the bus.

The same data input carries three kinds of byte, and a separate strobe marks each one: payload bytes, the identifier byte, and a received checksum byte. A mode input chooses the checksum variant. In classic mode only payload bytes count. In enhanced mode the identifier byte is also summed. A transmitting node pulses the finish strobe and reads the checksum. A receiving node presents the checksum byte it received with the check strobe, and the block reports whether it matches its own computed value. A clear strobe starts each new frame.

Top module: `lin_csum_top`

## Requirements
- R1: After reset is released, `csum_valid_o`, `csum_o`, `match_o` and `err_o` are all 0, and the accumulator holds 0x00.
- R2: In the cycle after `byte_valid_i` is high, the accumulator holds (acc + `data_i`). If that sum exceeds 0xFF, 0x100 is removed and 1 is added, so 0xFF + 0x01 gives 0x01.
- R3: In the cycle after `finish_i` is high, `csum_valid_o` is 1 and `csum_o` equals the bitwise inverse of the accumulator as it stood before that edge (0xFF XOR acc).
- R4: When `enhanced_i` is 0, a byte marked only by `id_valid_i` leaves the accumulator unchanged.
- R5: When `enhanced_i` is 1, a byte marked by `id_valid_i` is added exactly like a payload byte.
- R6: In the cycle after `clear_i` is high, the accumulator is 0x00 and `csum_valid_o`, `csum_o`, `match_o` and `err_o` are 0. Clear overrides every other strobe in the same cycle.
- R7: Once `csum_valid_o` is 1, `csum_o` holds its value and later bytes are not accumulated, until the next clear.
- R8: In the cycle after `check_i` is high, `data_i` has been compared with (0xFF XOR acc). `match_o` is 1 on equality and `err_o` is 1 otherwise, never both. `check_i` also completes the checksum as in R3, and the result holds until the next clear or check.
- R9: If `byte_valid_i` and `id_valid_i` are both high in one cycle, the byte is added once. A byte presented in the same cycle as `finish_i` or `check_i` is not accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Start a new frame: zero the accumulator and the results |
| byte_valid_i | input | 1 | `data_i` is a payload byte |
| id_valid_i | input | 1 | `data_i` is the identifier byte |
| enhanced_i | input | 1 | 1: identifier is included in the sum; 0: classic, data only |
| data_i | input | 8 | Byte value shared by all strobes |
| finish_i | input | 1 | End of frame: form the checksum |
| check_i | input | 1 | `data_i` is a received checksum to compare |
| csum_o | output | 8 | Final inverted checksum |
| csum_valid_o | output | 1 | `csum_o` is valid |
| match_o | output | 1 | Received checksum matched |
| err_o | output | 1 | Received checksum mismatched |

## Verification
Each result lands exactly one clock edge after its strobe. This applies to the accumulator update that follows a byte, to `csum_o` and `csum_valid_o` after finish or check, to `match_o` and `err_o` after check, and to the zeroed outputs after clear. The bench drives each cycle's inputs on the falling edge and advances a behavioural model once at the following rising edge. It then compares every output with the model on the next falling edge, so every comparison lands in the first cycle where a result is due. The sequences cover carry wrap-around, both checksum modes, strobes that coincide in one cycle, bytes sent after the checksum is frozen, and both outcomes of a compare.

// File: rtl/lin_csum_pkg.sv
package lin_csum_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DATA = 2'd1,
    SRC_ID   = 2'd2
  } src_e;
endpackage

// File: rtl/lin_csum_sel.sv
module lin_csum_sel
  import lin_csum_pkg::*;
(
  input  logic byte_valid_i,
  input  logic id_valid_i,
  input  logic enhanced_i,
  output src_e src_o,
  output logic add_en_o
);
  // payload wins over identifier when both strobe together
  always_comb begin
    if (byte_valid_i)                   src_o = SRC_DATA;
    else if (id_valid_i && enhanced_i)  src_o = SRC_ID;
    else                                src_o = SRC_NONE;
  end

  assign add_en_o = (src_o != SRC_NONE);
endmodule

// File: rtl/lin_csum_adder.sv
module lin_csum_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  localparam int unsigned SW = W + 1;

  logic [SW-1:0] raw;

  assign raw   = {1'b0, a_i} + {1'b0, b_i};
  // end-around carry; cannot carry again since max low part is 2^W-2
  assign sum_o = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
endmodule

// File: rtl/lin_csum_acc.sv
module lin_csum_acc #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         add_en_i,
  input  logic         freeze_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] acc_o,
  output logic         frozen_o
);
  logic [W-1:0] acc_q;
  logic [W-1:0] acc_sum;
  logic         frozen_q;

  lin_csum_adder #(.W(W)) u_add (
    .a_i   (acc_q),
    .b_i   (data_i),
    .sum_o (acc_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      frozen_q <= 1'b0;
    end else if (clear_i) begin
      acc_q    <= '0;
      frozen_q <= 1'b0;
    end else if (freeze_i) begin
      frozen_q <= 1'b1;
    end else if (add_en_i && !frozen_q) begin
      acc_q    <= acc_sum;
    end
  end

  assign acc_o    = acc_q;
  assign frozen_o = frozen_q;
endmodule

// File: rtl/lin_csum_out.sv
module lin_csum_out #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         finish_i,
  input  logic         check_i,
  input  logic         frozen_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] csum_o,
  output logic         valid_o,
  output logic         match_o,
  output logic         err_o
);
  logic [W-1:0] final_val;
  logic [W-1:0] csum_q;
  logic         valid_q, match_q, err_q;

  assign final_val = ~acc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csum_q  <= '0;
      valid_q <= 1'b0;
      match_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (clear_i) begin
      csum_q  <= '0;
      valid_q <= 1'b0;
      match_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if ((finish_i || check_i) && !frozen_i) begin
        csum_q  <= final_val;
        valid_q <= 1'b1;
      end
      if (check_i) begin
        match_q <= (data_i == final_val);
        err_q   <= (data_i != final_val);
      end
    end
  end

  assign csum_o  = csum_q;
  assign valid_o = valid_q;
  assign match_o = match_q;
  assign err_o   = err_q;
endmodule

// File: rtl/lin_csum_top.sv
module lin_csum_top
  import lin_csum_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         byte_valid_i,
  input  logic         id_valid_i,
  input  logic         enhanced_i,
  input  logic [W-1:0] data_i,
  input  logic         finish_i,
  input  logic         check_i,
  output logic [W-1:0] csum_o,
  output logic         csum_valid_o,
  output logic         match_o,
  output logic         err_o
);
  src_e         src;
  logic         add_en;
  logic [W-1:0] acc;
  logic         frozen;
  logic         freeze;

  assign freeze = finish_i || check_i;

  lin_csum_sel u_sel (
    .byte_valid_i (byte_valid_i),
    .id_valid_i   (id_valid_i),
    .enhanced_i   (enhanced_i),
    .src_o        (src),
    .add_en_o     (add_en)
  );

  lin_csum_acc #(.W(W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .add_en_i (add_en),
    .freeze_i (freeze),
    .data_i   (data_i),
    .acc_o    (acc),
    .frozen_o (frozen)
  );

  lin_csum_out #(.W(W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .finish_i (finish_i),
    .check_i  (check_i),
    .frozen_i (frozen),
    .acc_i    (acc),
    .data_i   (data_i),
    .csum_o   (csum_o),
    .valid_o  (csum_valid_o),
    .match_o  (match_o),
    .err_o    (err_o)
  );
endmodule

// File: rtl/lin_csum_chk.sv
module lin_csum_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clear_i,
  input logic         finish_i,
  input logic         check_i,
  input logic [W-1:0] csum_o,
  input logic         csum_valid_o,
  input logic         match_o,
  input logic         err_o
);
  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!csum_valid_o && !match_o && !err_o && csum_o == '0));

  assert_finish_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish_i && !clear_i) |=> csum_valid_o);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csum_valid_o && !clear_i) |=> (csum_valid_o && $stable(csum_o)));

  assert_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({match_o, err_o}));

  assert_check_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (check_i && !clear_i) |=> ((match_o || err_o) && csum_valid_o));

  assert_result_needs_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o || err_o) |-> csum_valid_o);
endmodule

bind lin_csum_top lin_csum_chk #(.W(W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clear_i      (clear_i),
  .finish_i     (finish_i),
  .check_i      (check_i),
  .csum_o       (csum_o),
  .csum_valid_o (csum_valid_o),
  .match_o      (match_o),
  .err_o        (err_o)
);

// File: tb/tb_lin_csum_top.sv
module tb_lin_csum_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0, byte_valid_i = 1'b0, id_valid_i = 1'b0;
  logic       enhanced_i = 1'b0, finish_i = 1'b0, check_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [7:0] csum_o;
  logic       csum_valid_o, match_o, err_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model state
  int  m_acc = 0, m_csum = 0;
  bit  m_valid = 0, m_match = 0, m_err = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  lin_csum_top dut (
    .clk_i, .rst_ni, .clear_i, .byte_valid_i, .id_valid_i, .enhanced_i,
    .data_i, .finish_i, .check_i, .csum_o, .csum_valid_o, .match_o, .err_o
  );

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check({tag, " csum_valid"}, csum_valid_o, m_valid);
    check({tag, " csum"},       csum_o,       m_csum);
    check({tag, " match"},      match_o,      m_match);
    check({tag, " err"},        err_o,        m_err);
  endtask

  function automatic int ones_add(int a, int b);
    int s;
    s = a + b;
    if (s > 255) s = s - 255;
    return s;
  endfunction

  // one clock: drive at negedge, step model at posedge, compare at next negedge
  task automatic step(string tag, bit clr, bit bv, bit iv, bit enh,
                      int d, bit fin, bit chk);
    bit f;
    clear_i = clr; byte_valid_i = bv; id_valid_i = iv; enhanced_i = enh;
    data_i = d[7:0]; finish_i = fin; check_i = chk;
    @(posedge clk_i);
    if (clr) begin
      m_acc = 0; m_valid = 0; m_csum = 0; m_match = 0; m_err = 0;
    end else begin
      f = fin || chk;
      if (chk) begin
        m_match = (d == 255 - m_acc);
        m_err   = !m_match;
      end
      if (f && !m_valid) begin
        m_csum = 255 - m_acc; m_valid = 1;
      end
      if (!f && !m_valid && (bv || (iv && enh)))
        m_acc = ones_add(m_acc, d);
    end
    @(negedge clk_i);
    clear_i = 0; byte_valid_i = 0; id_valid_i = 0; finish_i = 0; check_i = 0;
    compare_all(tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all("R1 reset");

    // classic frame with carry, id ignored
    step("R6 clear",      1, 0, 0, 0, 8'h00, 0, 0);
    step("R4 classic id", 0, 0, 1, 0, 8'h3C, 0, 0);
    step("R2 byte",       0, 1, 0, 0, 8'hFF, 0, 0);
    step("R2 carry",      0, 1, 0, 0, 8'h01, 0, 0);
    step("R2 byte",       0, 1, 0, 0, 8'h80, 0, 0);
    step("R2 carry",      0, 1, 0, 0, 8'h90, 0, 0);
    step("R3 finish",     0, 0, 0, 0, 8'h00, 1, 0);
    check("R3 value", csum_o, 8'hED); // 0x01+0x80+0x90 -> 0x11 +1 = 0x12, inv 0xED
    check("R4 id ignored", csum_o, 8'hED);
    step("R7 late byte",  0, 1, 0, 0, 8'h22, 0, 0);
    step("R7 late id",    0, 0, 1, 1, 8'h33, 0, 0);
    check("R7 hold", csum_o, 8'hED);
    step("R8 match",      0, 0, 0, 0, 8'hED, 0, 1);
    check("R8 match port", match_o, 1);
    step("R8 mismatch",   0, 0, 0, 0, 8'hEC, 0, 1);
    check("R8 err port", err_o, 1);
    step("R6 clear",      1, 1, 1, 1, 8'h44, 1, 1);
    check("R6 cleared", csum_valid_o, 0);

    // enhanced frame: id counted
    step("R5 enhanced id", 0, 0, 1, 1, 8'hC1, 0, 0);
    step("R5 byte",        0, 1, 0, 1, 8'h4A, 0, 0);
    step("R5 byte",        0, 1, 0, 1, 8'h55, 0, 0);
    step("R5 check",       0, 0, 0, 1, 8'h00, 0, 1);
    // 0xC1+0x4A=0x10B->0x0C; +0x55=0x61; inv 0x9E
    check("R5 value", csum_o, 8'h9E);
    check("R8 err on bad", err_o, 1);

    // coincident strobes
    step("R6 clear",       1, 0, 0, 0, 8'h00, 0, 0);
    step("R9 both strobes", 0, 1, 1, 1, 8'h10, 0, 0);
    step("R9 finish+byte", 0, 1, 0, 1, 8'h20, 1, 0);
    check("R9 value", csum_o, 8'hEF);

    // clear with byte in same cycle, then empty frame
    step("R6 clear+byte",  1, 1, 0, 0, 8'h77, 0, 0);
    step("R3 empty",       0, 0, 0, 0, 8'h00, 1, 0);
    check("R6 empty csum", csum_o, 8'hFF);

    // wrap to 0xFF accumulator gives zero checksum
    step("R6 clear",       1, 0, 0, 0, 8'h00, 0, 0);
    step("R2 byte",        0, 1, 0, 0, 8'hF0, 0, 0);
    step("R2 byte",        0, 1, 0, 0, 8'h0F, 0, 0);
    step("R8 check zero",  0, 0, 0, 0, 8'h00, 0, 1);
    check("R8 zero match", match_o, 1);
    check("R3 zero csum", csum_o, 8'h00);

    summary();
  end
endmodule